// File: doc/BRIEF.md
# CAN Acceptance Filter Bank Matcher

This block decides whether a received CAN frame is wanted. It compares the frame's identifier, together with its extended-format flag and remote-request flag, against a row of programmable filter banks. Each bank holds two 32-bit words. A layout field of two bits, one for scale and one for mode, sets how the bank reads those words: as 16-bit identifier/mask pairs, as a list of four 16-bit identifiers, as one 32-bit identifier with a 32-bit mask, or as a list of two 32-bit identifiers.

Filters are numbered by a running count. A filter's number is the sum of the filter counts of every lower-numbered bank, plus the filter's position inside its own bank. When a frame hits, the block reports the lowest such number. The next stage can use it to pick a handler. A host port writes the per-bank layout bits, the active bits, the bank words and a global configuration lock.

Results come out of a two-stage pipeline. The pipeline accepts one frame per cycle.

Top module: `can_acc_filter`

## Requirements
- R1: The layout code of bank b is {scale[b], mode[b]}. Code 00 is 16-bit mask and holds 2 filters. Code 01 is 16-bit list and holds 4. Code 10 is 32-bit mask and holds 1. Code 11 is 32-bit list and holds 2.
- R2: The 32-bit frame image is built as follows. Bits [31:21] carry the standard identifier, or bits [28:18] of an extended identifier. Bits [20:3] carry extended identifier bits [17:0], or zero for a standard frame. Bit 2 is the extended flag, bit 1 is the remote flag and bit 0 is zero. A 32-bit list bank hits on an exact compare: filter 0 against word 1, filter 1 against word 2.
- R3: The 16-bit frame image is {image32[31:21], remote, extended, image32[20:18]}. A 16-bit list bank compares it exactly against four slots, in this order: word 1 [15:0], word 1 [31:16], word 2 [15:0], word 2 [31:16].
- R4: In a 16-bit mask bank, filter 0 uses word 1 and filter 1 uses word 2. Bits [15:0] of the word are the identifier and bits [31:16] are the mask. A 32-bit mask bank uses word 1 as the identifier and word 2 as the mask. A mask bit of 1 means the image bit must equal the identifier bit.
- R5: In mask layouts the extended-flag bit is always compared, whatever the mask holds. Standard filters never accept extended frames, and extended filters never accept standard frames.
- R6: The match index is the filter count of all lower-numbered banks, plus the slot within the bank. Inactive banks still count.
- R7: When several filters hit, the lowest index is reported.
- R8: A bank whose active bit is 0 never hits.
- R9: The register map is: 0 = lock in bit 0; 1 = mode bits; 2 = scale bits; 3 = active bits; 4+2b = word 1 of bank b; 5+2b = word 2 of bank b. Mode, scale and word writes take effect only while the lock is 1. Lock and active writes always take effect.
- R10: A frame whose strobe cycle sees the lock at 1 produces no hit.
- R11: For a strobe in cycle t, match_vld pulses in cycle t+2. With it come match_hit and, on a hit, match_idx; on a miss match_idx is 0. Frames may arrive every cycle. A frame is judged against the configuration held before any write made in its own strobe cycle.
- R12: Reset clears all configuration and outputs, so every frame after reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_vld | input | 1 | Frame strobe, one cycle per frame |
| frm_ide | input | 1 | Frame uses a 29-bit identifier |
| frm_rtr | input | 1 | Frame is a remote request |
| frm_id | input | 29 | Identifier; a standard frame uses bits [10:0] |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(4+2*NUM_BANKS) (5) | Register address |
| cfg_wdata | input | 32 | Register write data |
| match_vld | output | 1 | Result pulse, two cycles after the strobe |
| match_hit | output | 1 | Frame accepted |
| match_idx | output | $clog2(4*NUM_BANKS+1) (6) | Flat index of the winning filter |

## Verification
A host write and a frame strobe can land in the same cycle. This is the key collision: a write to the lock or to the active bits meets a frame in flight. The bench drives both on one clock edge. It expects the frame to be judged on the state before the write, so the hit is still reported. A second frame, one cycle later, must then show the new state. The bench also changes a bank's layout under the lock and checks that the indices of every higher bank shift by the change in filter count.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;

   typedef enum logic [1:0] {
      LAY_MASK16 = 2'b00,
      LAY_LIST16 = 2'b01,
      LAY_MASK32 = 2'b10,
      LAY_LIST32 = 2'b11
   } lay_e;

   localparam logic [31:0] IDE_BIT32 = 32'h0000_0004;
   localparam logic [15:0] IDE_BIT16 = 16'h0008;

   // filters carried by one bank for a given layout
   function automatic logic [2:0] lay_count(lay_e t);
      case (t)
         LAY_MASK16: lay_count = 3'd2;
         LAY_LIST16: lay_count = 3'd4;
         LAY_MASK32: lay_count = 3'd1;
         default:    lay_count = 3'd2;
      endcase
   endfunction

   function automatic logic [31:0] frame_img32(logic ide, logic rtr, logic [28:0] id);
      if (ide) frame_img32 = {id, 1'b1, rtr, 1'b0};
      else     frame_img32 = {id[10:0], 18'd0, 1'b0, rtr, 1'b0};
   endfunction

   function automatic logic [15:0] frame_img16(logic [31:0] i32);
      frame_img16 = {i32[31:21], i32[1], i32[2], i32[20:18]};
   endfunction

   function automatic logic [1:0] first_slot(logic [3:0] h);
      if (h[0])      first_slot = 2'd0;
      else if (h[1]) first_slot = 2'd1;
      else if (h[2]) first_slot = 2'd2;
      else           first_slot = 2'd3;
   endfunction

endpackage

// File: rtl/can_flt_cfg.sv
module can_flt_cfg #(
   parameter int NUM_BANKS = 8,
   parameter int AW        = $clog2(4 + 2*NUM_BANKS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr,
   input  logic [AW-1:0]                addr,
   input  logic [31:0]                  wdata,
   output logic                         lock_o,
   output logic [NUM_BANKS-1:0]         mode_o,
   output logic [NUM_BANKS-1:0]         scale_o,
   output logic [NUM_BANKS-1:0]         act_o,
   output logic [NUM_BANKS-1:0][31:0]   w1_o,
   output logic [NUM_BANKS-1:0][31:0]   w2_o
);
   localparam int A_LOCK  = 0;
   localparam int A_MODE  = 1;
   localparam int A_SCALE = 2;
   localparam int A_ACT   = 3;
   localparam int A_WORD0 = 4;

   logic                       lock_q;
   logic [NUM_BANKS-1:0]       mode_q, scale_q, act_q;
   logic [NUM_BANKS-1:0][31:0] w1_q, w2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q  <= 1'b0;
         mode_q  <= '0;
         scale_q <= '0;
         act_q   <= '0;
         w1_q    <= '0;
         w2_q    <= '0;
      end else if (wr) begin
         if (int'(addr) == A_LOCK)  lock_q <= wdata[0];
         if (int'(addr) == A_ACT)   act_q  <= wdata[NUM_BANKS-1:0];
         if (lock_q) begin
            if (int'(addr) == A_MODE)  mode_q  <= wdata[NUM_BANKS-1:0];
            if (int'(addr) == A_SCALE) scale_q <= wdata[NUM_BANKS-1:0];
            for (int b = 0; b < NUM_BANKS; b++) begin
               if (int'(addr) == A_WORD0 + 2*b)     w1_q[b] <= wdata;
               if (int'(addr) == A_WORD0 + 2*b + 1) w2_q[b] <= wdata;
            end
         end
      end
   end

   assign lock_o  = lock_q;
   assign mode_o  = mode_q;
   assign scale_o = scale_q;
   assign act_o   = act_q;
   assign w1_o    = w1_q;
   assign w2_o    = w2_q;

   // R9
   mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(lock_q) |-> $stable(mode_q));

   // R9
   scale_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(lock_q) |-> $stable(scale_q));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_wchk
      // R9
      word_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(lock_q) |-> ($stable(w1_q[b]) && $stable(w2_q[b])));
   end

endmodule

// File: rtl/can_flt_bank.sv
module can_flt_bank
   import can_flt_pkg::*;
(
   input  logic        mode,
   input  logic        scale,
   input  logic        act,
   input  logic [31:0] w1,
   input  logic [31:0] w2,
   input  logic [31:0] img32,
   input  logic [15:0] img16,
   output logic [3:0]  hit
);
   lay_e lay;
   logic [3:0] raw;

   assign lay = lay_e'({scale, mode});

   always_comb begin
      raw = '0;
      case (lay)
         LAY_LIST16: begin
            raw[0] = (img16 == w1[15:0]);
            raw[1] = (img16 == w1[31:16]);
            raw[2] = (img16 == w2[15:0]);
            raw[3] = (img16 == w2[31:16]);
         end
         LAY_MASK16: begin
            raw[0] = (((img16 ^ w1[15:0]) & (w1[31:16] | IDE_BIT16)) == 16'd0);
            raw[1] = (((img16 ^ w2[15:0]) & (w2[31:16] | IDE_BIT16)) == 16'd0);
         end
         LAY_MASK32: begin
            raw[0] = (((img32 ^ w1) & (w2 | IDE_BIT32)) == 32'd0);
         end
         default: begin
            raw[0] = (img32 == w1);
            raw[1] = (img32 == w2);
         end
      endcase
   end

   assign hit = act ? raw : 4'd0;

endmodule

// File: rtl/can_flt_pick.sv
module can_flt_pick
   import can_flt_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int IW        = $clog2(4*NUM_BANKS + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_vld,
   input  logic [NUM_BANKS-1:0][3:0]   in_hits,
   input  logic [NUM_BANKS-1:0][1:0]   in_lay,
   output logic                        out_vld,
   output logic                        out_hit,
   output logic [IW-1:0]               out_idx
);
   logic          found;
   logic [IW-1:0] base, idx_c, total;

   always_comb begin
      base  = '0;
      found = 1'b0;
      idx_c = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (!found && (in_hits[b] != 4'd0)) begin
            found = 1'b1;
            idx_c = base + IW'(first_slot(in_hits[b]));
         end
         base = base + IW'(lay_count(lay_e'(in_lay[b])));
      end
      total = base;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_hit <= 1'b0;
         out_idx <= '0;
      end else begin
         out_vld <= in_vld;
         out_hit <= in_vld && found;
         out_idx <= (in_vld && found) ? idx_c : '0;
      end
   end

   // R6
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_hit |-> (out_idx < $past(total)));

endmodule

// File: rtl/can_acc_filter.sv
module can_acc_filter
   import can_flt_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int AW        = $clog2(4 + 2*NUM_BANKS),
   parameter int IW        = $clog2(4*NUM_BANKS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frm_vld,
   input  logic          frm_ide,
   input  logic          frm_rtr,
   input  logic [28:0]   frm_id,
   input  logic          cfg_wr,
   input  logic [AW-1:0] cfg_addr,
   input  logic [31:0]   cfg_wdata,
   output logic          match_vld,
   output logic          match_hit,
   output logic [IW-1:0] match_idx
);
   if (NUM_BANKS < 1 || NUM_BANKS > 32) begin : g_bad_banks
      $error("NUM_BANKS must be 1..32");
   end
   if (AW < $clog2(4 + 2*NUM_BANKS)) begin : g_bad_aw
      $error("AW too narrow for the register map");
   end
   if (IW < $clog2(4*NUM_BANKS + 1)) begin : g_bad_iw
      $error("IW too narrow for the match index");
   end

   logic                       lock;
   logic [NUM_BANKS-1:0]       mode, scale, act;
   logic [NUM_BANKS-1:0][31:0] w1, w2;
   logic [NUM_BANKS-1:0][3:0]  raw_hits;
   logic [NUM_BANKS-1:0][1:0]  lay_now;
   logic [31:0]                img32;
   logic [15:0]                img16;

   logic                       s1_vld;
   logic [NUM_BANKS-1:0][3:0]  s1_hits;
   logic [NUM_BANKS-1:0][1:0]  s1_lay;

   can_flt_cfg #(.NUM_BANKS(NUM_BANKS), .AW(AW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
      .lock_o(lock), .mode_o(mode), .scale_o(scale), .act_o(act),
      .w1_o(w1), .w2_o(w2)
   );

   assign img32 = frame_img32(frm_ide, frm_rtr, frm_id);
   assign img16 = frame_img16(img32);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      can_flt_bank u_bank (
         .mode(mode[b]), .scale(scale[b]), .act(act[b]),
         .w1(w1[b]), .w2(w2[b]),
         .img32(img32), .img16(img16),
         .hit(raw_hits[b])
      );
      assign lay_now[b] = {scale[b], mode[b]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_hits <= '0;
         s1_lay  <= '0;
      end else begin
         s1_vld <= frm_vld;
         if (frm_vld) begin
            s1_hits <= lock ? '0 : raw_hits;
            s1_lay  <= lay_now;
         end
      end
   end

   can_flt_pick #(.NUM_BANKS(NUM_BANKS), .IW(IW)) u_pick (
      .clk(clk), .rst_n(rst_n),
      .in_vld(s1_vld), .in_hits(s1_hits), .in_lay(s1_lay),
      .out_vld(match_vld), .out_hit(match_hit), .out_idx(match_idx)
   );

   // R11
   match_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_vld |-> $past(frm_vld, 2));

   // R11
   hit_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_hit |-> match_vld);

   // R10
   lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_vld && $past(lock)) |=> !match_hit);

endmodule

// File: tb/sim_can_acc_filter.sv
`timescale 1ns/1ps
module sim_can_acc_filter;
   localparam int NB = 8;
   localparam int AW = $clog2(4 + 2*NB);
   localparam int IW = $clog2(4*NB + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frm_vld = 1'b0, frm_ide = 1'b0, frm_rtr = 1'b0;
   logic [28:0]   frm_id = '0;
   logic          cfg_wr = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          match_vld, match_hit;
   logic [IW-1:0] match_idx;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   can_acc_filter #(.NUM_BANKS(NB)) u0 (
      .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_ide(frm_ide),
      .frm_rtr(frm_rtr), .frm_id(frm_id), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .match_vld(match_vld), .match_hit(match_hit),
      .match_idx(match_idx)
   );

   typedef struct packed {
      logic        ide;
      logic        rtr;
      logic [28:0] id;
      logic        hit;
      logic [5:0]  idx;
   } vec_t;

   // bank0 32-bit mask ext 0x12345xx (idx0); bank1 16-bit list 0x100,0x101,0x102,0x7FF (idx1..4);
   // bank2 inactive 32-bit list (idx5,6); bank3 16-bit mask 0x10x any rtr (idx7), 0x200 rtr (idx8);
   // bank4 32-bit list std 0x123 (idx9), ext 0xABCDEF (idx10)
   localparam vec_t VEC [13] = '{
      '{1'b1, 1'b0, 29'h1234567, 1'b1, 6'd0},   // R4 32-bit mask
      '{1'b1, 1'b1, 29'h1234567, 1'b1, 6'd0},   // R4 remote bit masked off
      '{1'b1, 1'b0, 29'h1234667, 1'b0, 6'd0},   // R4 masked bits differ
      '{1'b0, 1'b0, 29'h0000100, 1'b1, 6'd1},   // R7 bank1 beats bank3
      '{1'b0, 1'b0, 29'h0000102, 1'b1, 6'd3},   // R3 slot 2
      '{1'b0, 1'b0, 29'h00007FF, 1'b1, 6'd4},   // R3 slot 3
      '{1'b0, 1'b0, 29'h0000105, 1'b1, 6'd7},   // R4 16-bit mask
      '{1'b0, 1'b1, 29'h0000100, 1'b1, 6'd7},   // R3 list needs remote 0
      '{1'b0, 1'b1, 29'h0000200, 1'b1, 6'd8},   // R4 remote required
      '{1'b0, 1'b0, 29'h0000200, 1'b0, 6'd0},   // R4 remote mismatch
      '{1'b0, 1'b0, 29'h0000123, 1'b1, 6'd9},   // R8 R6 inactive bank2 skipped, counted
      '{1'b1, 1'b0, 29'h0ABCDEF, 1'b1, 6'd10},  // R2 extended list
      '{1'b1, 1'b0, 29'h4000000, 1'b0, 6'd0}    // R5 ext frame vs std filters
   };

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic send(logic ide, logic rtr, logic [28:0] id, logic eh, int ei, string tag);
      @(negedge clk);
      frm_vld = 1'b1; frm_ide = ide; frm_rtr = rtr; frm_id = id;
      @(negedge clk);
      frm_vld = 1'b0;
      check({tag, " early vld"}, 32'(match_vld), 32'd0);
      @(negedge clk);
      check({tag, " vld"}, 32'(match_vld), 32'd1);
      check({tag, " hit"}, 32'(match_hit), 32'(eh));
      check({tag, " idx"}, 32'(match_idx), 32'(ei));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R12 reset vld", 32'(match_vld), 32'd0);
      check("R12 reset hit", 32'(match_hit), 32'd0);
      rst_n = 1'b1;
      send(1'b0, 1'b0, 29'h0, 1'b0, 0, "R12 empty config");

      // configure under lock
      wr(0, 32'h1);
      wr(1, 32'h16);
      wr(2, 32'h15);
      wr(4, 32'h091A_2804); wr(5, 32'hFFFF_F800);
      wr(6, 32'h2020_2000); wr(7, 32'hFFE0_2040);
      wr(8, 32'h2460_0000); wr(9, 32'h0);
      wr(10, 32'hFE00_2000); wr(11, 32'hFFF0_4010);
      wr(12, 32'h2460_0000); wr(13, 32'h055E_6F7C);
      wr(3, 32'h1B);
      wr(0, 32'h0);

      for (int i = 0; i < 13; i++) begin
         send(VEC[i].ide, VEC[i].rtr, VEC[i].id, VEC[i].hit, int'(VEC[i].idx),
              $sformatf("R1 vector %0d", i));
      end

      // R9: unlocked writes to words and mode ignored
      wr(12, 32'h2480_0000);
      wr(1, 32'hFF);
      send(1'b0, 1'b0, 29'h123, 1'b1, 9, "R9 word write ignored");
      send(1'b0, 1'b0, 29'h105, 1'b1, 7, "R9 mode write ignored");

      // R10: lock suppresses hits
      wr(0, 32'h1);
      send(1'b0, 1'b0, 29'h100, 1'b0, 0, "R10 locked");

      // R6: bank1 becomes 32-bit mask, higher indices shift
      wr(1, 32'h14);
      wr(2, 32'h17);
      wr(6, 32'h0); wr(7, 32'hFFFF_FFFF);
      wr(0, 32'h0);
      send(1'b0, 1'b0, 29'h105, 1'b1, 4, "R6 shifted index");
      send(1'b0, 1'b0, 29'h000, 1'b1, 1, "R4 32-bit mask exact");
      send(1'b0, 1'b0, 29'h100, 1'b1, 4, "R6 bank3 after relayout");

      // R8: active bit cleared while unlocked
      wr(3, 32'h1A);
      send(1'b1, 1'b0, 29'h1234567, 1'b0, 0, "R8 deactivated bank");

      // R11: same-cycle active write and frame; frame sees old config
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = AW'(3); cfg_wdata = 32'h0A;
      frm_vld = 1'b1; frm_ide = 1'b0; frm_rtr = 1'b0; frm_id = 29'h123;
      @(negedge clk);
      cfg_wr = 1'b0; frm_vld = 1'b0;
      @(negedge clk);
      check("R11 collision vld", 32'(match_vld), 32'd1);
      check("R11 collision hit", 32'(match_hit), 32'd1);
      check("R11 collision idx", 32'(match_idx), 32'd6);
      send(1'b0, 1'b0, 29'h123, 1'b0, 0, "R11 after collision");

      // R11: back-to-back frames
      @(negedge clk);
      frm_vld = 1'b1; frm_id = 29'h105;
      @(negedge clk);
      frm_id = 29'h000;
      @(negedge clk);
      frm_vld = 1'b0;
      check("R11 b2b first vld", 32'(match_vld), 32'd1);
      check("R11 b2b first idx", 32'(match_idx), 32'd4);
      @(negedge clk);
      check("R11 b2b second vld", 32'(match_vld), 32'd1);
      check("R11 b2b second idx", 32'(match_idx), 32'd1);

      // R10: lock write in the strobe cycle does not affect that frame
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = AW'(0); cfg_wdata = 32'h1;
      frm_vld = 1'b1; frm_id = 29'h105;
      @(negedge clk);
      cfg_wr = 1'b0; frm_vld = 1'b0;
      @(negedge clk);
      check("R10 lock collision hit", 32'(match_hit), 32'd1);
      check("R10 lock collision idx", 32'(match_idx), 32'd4);
      send(1'b0, 1'b0, 29'h105, 1'b0, 0, "R10 lock after collision");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule